// File: doc/BRIEF.md
# Pipeline Hazard Interlock Unit

This unit decides, every cycle, whether a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) can let the instruction in decode move forward. It is given the pre-decoded register fields and flags of the decode, execute, memory and writeback stages. From these it drives four kinds of control: a hold for fetch and decode, a bubble into execute, operand-source selects for the execute-stage bypass multiplexers, and squash signals for instructions fetched down the wrong path after a taken branch. Instruction decode, the register file and the ALU stay outside the unit.

Two parameters pick the variant. `FWD_MODE` sets the bypass network: no bypass at all, only the path that starts at writeback and ends at execute, or the full set (the execute result and the memory-stage result both feed execute). `BR_STAGE` sets where branches resolve: in execute, which costs two squashed fetches when a branch is taken, or in decode, which costs one. When branches resolve in decode, the branch comparator needs its operands a stage earlier. A branch operand that is still being produced therefore stalls decode, unless full forwarding lets it be taken from the memory stage. The register file is assumed to write in the first half of the cycle and read in the second, so a result that is in writeback is already visible to decode.

Top module: `hazard_interlock`

## Requirements
- R1: While `rst` is high at a rising edge, both execute operand selects are 0 (register file) after that edge.
- R2: Register number 0 never causes a stall or a forward, whichever stage writes it.
- R3: With no bypass, decode stalls while a producer of a used source is in execute or memory. A producer in writeback causes no stall, because the register file writes before it is read.
- R4: With only the writeback-to-execute path, decode stalls only for a producer in execute. A producer in memory lets the consumer advance, and the next cycle's select for that operand is 2 (writeback value).
- R5: With full forwarding, a non-load producer in execute causes no stall, and the next select is 1 (memory-stage value). A producer in memory gives a next select of 2.
- R6: A load in execute with a dependent instruction right behind it in decode stalls that instruction in every bypass variant. A load already in memory is forwarded with select 2 where a writeback path exists.
- R7: `stall_if` and `stall_id` are always equal, and `bubble_ex` is high with them. In the cycle after a bubble both selects are 0.
- R8: With branches resolved in execute, `br_taken` raises `flush_if`, `flush_id` and `bubble_ex` and overrides any stall, so two fetches are squashed and the selects return to 0.
- R9: With branches resolved in decode, a taken branch raises only `flush_if`, so one fetch is squashed. This happens only when `id_branch` is set and decode is not stalled. While the branch waits on an operand, `br_taken` has no effect.
- R10: A branch that resolves in decode stalls for a producer in execute, and for a producer in memory that is a load or when the bypass is not full. With full bypass and a non-load producer in memory, `id_fwd_a`/`id_fwd_b` go high and there is no stall.
- R11: When execute and memory both write the register a consumer reads, the newer value (from execute) is the one selected.
- R12: A source whose use flag is low never causes a stall or a forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1 | input | RW | First source register of the decode instruction |
| id_use1 | input | 1 | First source is read |
| id_rs2 | input | RW | Second source register of the decode instruction |
| id_use2 | input | 1 | Second source is read |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| ex_rd | input | RW | Destination register in execute |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | RW | Destination register in memory |
| mem_wen | input | 1 | Memory instruction writes a register |
| mem_load | input | 1 | Memory instruction is a load |
| wb_rd | input | RW | Destination register in writeback |
| wb_wen | input | 1 | Writeback instruction writes a register |
| br_taken | input | 1 | Branch in the resolving stage is taken |
| stall_if | output | 1 | Hold the fetch stage |
| stall_id | output | 1 | Hold the decode stage |
| bubble_ex | output | 1 | Load a no-op into execute next cycle |
| flush_if | output | 1 | Squash the instruction now in fetch |
| flush_id | output | 1 | Squash the instruction now in decode |
| fwd_a | output | 2 | Registered execute select, operand 1: 0 register file, 1 memory-stage value, 2 writeback value |
| fwd_b | output | 2 | Registered execute select, operand 2, same encoding |
| id_fwd_a | output | 1 | Decode branch operand 1 taken from the memory stage |
| id_fwd_b | output | 1 | Decode branch operand 2 taken from the memory stage |

## Verification
The hardest situations to reach are the ones where two rules meet in one cycle. One is a taken branch arriving while decode holds a dependent instruction: in execute-resolution builds the flush must win, but in decode-resolution builds the stall must win and the taken flag must be ignored. The other is a register written by both execute and memory, where the priority decides the select. The stimulus drives the stage fields directly, so each of these combined states is placed in a single cycle. The same inputs go to four instances at once (no bypass, writeback-only, full with execute branches, and full with decode branches), and each instance is given its own expected reaction, so one cycle exercises every variant's rule.

// File: rtl/hz_pkg.sv
package hz_pkg;
  parameter int FWD_NONE = 0;
  parameter int FWD_WB   = 1;
  parameter int FWD_FULL = 2;

  parameter int BR_AT_EX = 0;
  parameter int BR_AT_ID = 1;

  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_MEM = 2'd1,
    SRC_WB  = 2'd2
  } src_e;
endpackage

// File: rtl/hz_match.sv
module hz_match #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] rs,
  input  logic          use_op,
  input  logic [RW-1:0] rd,
  input  logic          wen,
  output logic          hit
);
  assign hit = use_op && wen && (rd != '0) && (rs == rd);
endmodule

// File: rtl/hz_operand.sv
module hz_operand
  import hz_pkg::*;
#(
  parameter int RW        = 5,
  parameter int FWD_MODE  = FWD_FULL,
  parameter int RF_BYPASS = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] rs,
  input  logic          use_op,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_load,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_wen,
  output logic          norm_stall,
  output logic          br_stall,
  output logic          br_fwd,
  output src_e          src_nxt
);
  localparam int NST = 3;
  localparam logic WB_BLOCKS = (RF_BYPASS == 0);
  localparam logic IS_FULL   = (FWD_MODE == FWD_FULL);

  logic [RW-1:0]  st_rd [NST];
  logic [NST-1:0] st_wen;
  logic [NST-1:0] hit;
  logic           wb_hold;

  assign st_rd[0] = ex_rd;
  assign st_rd[1] = mem_rd;
  assign st_rd[2] = wb_rd;
  assign st_wen   = {wb_wen, mem_wen, ex_wen};

  for (genvar k = 0; k < NST; k++) begin : g_stage
    hz_match #(.RW(RW)) u_match (
      .rs    (rs),
      .use_op(use_op),
      .rd    (st_rd[k]),
      .wen   (st_wen[k]),
      .hit   (hit[k])
    );
  end

  assign wb_hold = hit[2] && WB_BLOCKS;

  if (FWD_MODE == FWD_NONE) begin : g_none
    assign norm_stall = hit[0] || hit[1] || wb_hold;
    assign src_nxt    = SRC_RF;
  end else if (FWD_MODE == FWD_WB) begin : g_wb
    assign norm_stall = hit[0] || wb_hold;
    assign src_nxt    = hit[1] ? SRC_WB : SRC_RF;
  end else begin : g_full
    assign norm_stall = (hit[0] && ex_load) || wb_hold;
    assign src_nxt    = hit[0] ? (ex_load ? SRC_RF : SRC_MEM)
                      : (hit[1] ? SRC_WB : SRC_RF);
  end

  // operands of a decode-stage branch are needed one stage earlier
  assign br_stall = hit[0] || (hit[1] && (!IS_FULL || mem_load)) || wb_hold;
  assign br_fwd   = IS_FULL && hit[1] && !mem_load && !hit[0];

  AST_LOAD_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
    (hit[0] && ex_load) |-> (src_nxt != SRC_MEM)); // R6
  AST_REG0_SILENT: assert property (@(posedge clk) disable iff (rst)
    (rs == '0) |-> (!norm_stall && !br_stall && !br_fwd && src_nxt == SRC_RF)); // R2
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
#(
  parameter int NOPS     = 2,
  parameter int BR_STAGE = BR_AT_EX
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NOPS-1:0] norm_stall,
  input  logic [NOPS-1:0] br_stall,
  input  logic [NOPS-1:0] br_fwd,
  input  logic            id_branch,
  input  logic            br_taken,
  output logic            stall,
  output logic            bubble,
  output logic            flush_if,
  output logic            flush_id,
  output logic            advance,
  output logic [NOPS-1:0] id_fwd
);
  localparam logic AT_ID = (BR_STAGE == BR_AT_ID);

  logic hazard;

  assign hazard = (|norm_stall) || (AT_ID && id_branch && (|br_stall));

  if (BR_STAGE == BR_AT_ID) begin : g_id
    assign stall    = hazard;
    assign flush_if = br_taken && id_branch && !hazard;
    assign flush_id = 1'b0;
  end else begin : g_ex
    assign stall    = hazard && !br_taken;
    assign flush_if = br_taken;
    assign flush_id = br_taken;
  end

  assign bubble  = stall || flush_id;
  assign advance = !bubble;
  assign id_fwd  = (AT_ID && id_branch) ? br_fwd : '0;

  AST_FWD_NEEDS_FREE: assert property (@(posedge clk) disable iff (rst)
    (|id_fwd) |-> !(|norm_stall && AT_ID && |br_stall)); // R10
endmodule

// File: rtl/hz_fwd_reg.sv
module hz_fwd_reg
  import hz_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic advance,
  input  src_e src_nxt,
  output src_e src_q
);
  always_ff @(posedge clk) begin
    if (rst)          src_q <= SRC_RF;
    else if (advance) src_q <= src_nxt;
    else              src_q <= SRC_RF;
  end
endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
  import hz_pkg::*;
#(
  parameter int RW        = 5,
  parameter int FWD_MODE  = FWD_FULL,
  parameter int BR_STAGE  = BR_AT_EX,
  parameter int RF_BYPASS = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] id_rs1,
  input  logic          id_use1,
  input  logic [RW-1:0] id_rs2,
  input  logic          id_use2,
  input  logic          id_branch,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_load,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_wen,
  input  logic          br_taken,
  output logic          stall_if,
  output logic          stall_id,
  output logic          bubble_ex,
  output logic          flush_if,
  output logic          flush_id,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          id_fwd_a,
  output logic          id_fwd_b
);
  localparam int NOPS = 2;

  logic [RW-1:0]   op_rs  [NOPS];
  logic [NOPS-1:0] op_use;
  logic [NOPS-1:0] norm_stall, br_stall, br_fwd, id_fwd;
  src_e            src_nxt [NOPS];
  src_e            src_q   [NOPS];
  logic            stall, advance;

  assign op_rs[0] = id_rs1;
  assign op_rs[1] = id_rs2;
  assign op_use   = {id_use2, id_use1};

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    hz_operand #(.RW(RW), .FWD_MODE(FWD_MODE), .RF_BYPASS(RF_BYPASS)) u_op (
      .clk       (clk),
      .rst       (rst),
      .rs        (op_rs[g]),
      .use_op    (op_use[g]),
      .ex_rd     (ex_rd),
      .ex_wen    (ex_wen),
      .ex_load   (ex_load),
      .mem_rd    (mem_rd),
      .mem_wen   (mem_wen),
      .mem_load  (mem_load),
      .wb_rd     (wb_rd),
      .wb_wen    (wb_wen),
      .norm_stall(norm_stall[g]),
      .br_stall  (br_stall[g]),
      .br_fwd    (br_fwd[g]),
      .src_nxt   (src_nxt[g])
    );

    hz_fwd_reg u_sel (
      .clk    (clk),
      .rst    (rst),
      .advance(advance),
      .src_nxt(src_nxt[g]),
      .src_q  (src_q[g])
    );
  end

  hz_ctrl #(.NOPS(NOPS), .BR_STAGE(BR_STAGE)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .norm_stall(norm_stall),
    .br_stall  (br_stall),
    .br_fwd    (br_fwd),
    .id_branch (id_branch),
    .br_taken  (br_taken),
    .stall     (stall),
    .bubble    (bubble_ex),
    .flush_if  (flush_if),
    .flush_id  (flush_id),
    .advance   (advance),
    .id_fwd    (id_fwd)
  );

  assign stall_if = stall;
  assign stall_id = stall;
  assign fwd_a    = src_q[0];
  assign fwd_b    = src_q[1];
  assign id_fwd_a = id_fwd[0];
  assign id_fwd_b = id_fwd[1];

  AST_RESET_SEL: assert property (@(posedge clk)
    rst |=> (fwd_a == 2'd0 && fwd_b == 2'd0)); // R1
  AST_LOAD_USE: assert property (@(posedge clk) disable iff (rst)
    (ex_wen && ex_load && ex_rd != '0 && id_use1 && id_rs1 == ex_rd && !flush_id)
      |-> stall_id); // R6
  AST_BUBBLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    bubble_ex |=> (fwd_a == 2'd0 && fwd_b == 2'd0)); // R7

  if (BR_STAGE == BR_AT_EX) begin : g_chk_ex
    AST_EX_FLUSH: assert property (@(posedge clk) disable iff (rst)
      br_taken |-> (flush_if && flush_id && bubble_ex && !stall_id)); // R8
  end else begin : g_chk_id
    AST_ID_FLUSH: assert property (@(posedge clk) disable iff (rst)
      flush_if |-> (!flush_id && !stall_id && id_branch && br_taken)); // R9
  end
endmodule

// File: tb/tb_hazard_interlock.sv
module tb_hazard_interlock;
  import hz_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [RW-1:0] id_rs1, id_rs2, ex_rd, mem_rd, wb_rd;
  logic id_use1, id_use2, id_branch, ex_wen, ex_load, mem_wen, mem_load, wb_wen, br_taken;

  typedef struct packed {
    logic sif; logic sid; logic bub; logic fif; logic fid;
    logic [1:0] fa; logic [1:0] fb; logic da; logic db;
  } obs_t;

  typedef struct {
    int    d;
    string req;
    obs_t  e;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  obs_t o [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  // 0: no bypass, 1: writeback path only, 2 (dut): full + execute branches, 3: full + decode branches
  for (genvar i = 0; i < 4; i++) begin : g_dut
    localparam int FM = (i == 0) ? FWD_NONE : (i == 1) ? FWD_WB : FWD_FULL;
    localparam int BS = (i == 3) ? BR_AT_ID : BR_AT_EX;
    logic sif, sid, bub, fif, fid, da, db;
    logic [1:0] fa, fb;
    if (i == 2) begin : g_main
      hazard_interlock #(.RW(RW), .FWD_MODE(FM), .BR_STAGE(BS)) dut (
        .clk(clk), .rst(rst), .id_rs1(id_rs1), .id_use1(id_use1), .id_rs2(id_rs2),
        .id_use2(id_use2), .id_branch(id_branch), .ex_rd(ex_rd), .ex_wen(ex_wen),
        .ex_load(ex_load), .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_load(mem_load),
        .wb_rd(wb_rd), .wb_wen(wb_wen), .br_taken(br_taken), .stall_if(sif),
        .stall_id(sid), .bubble_ex(bub), .flush_if(fif), .flush_id(fid),
        .fwd_a(fa), .fwd_b(fb), .id_fwd_a(da), .id_fwd_b(db));
    end else begin : g_var
      hazard_interlock #(.RW(RW), .FWD_MODE(FM), .BR_STAGE(BS)) dut_v (
        .clk(clk), .rst(rst), .id_rs1(id_rs1), .id_use1(id_use1), .id_rs2(id_rs2),
        .id_use2(id_use2), .id_branch(id_branch), .ex_rd(ex_rd), .ex_wen(ex_wen),
        .ex_load(ex_load), .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_load(mem_load),
        .wb_rd(wb_rd), .wb_wen(wb_wen), .br_taken(br_taken), .stall_if(sif),
        .stall_id(sid), .bubble_ex(bub), .flush_if(fif), .flush_id(fid),
        .fwd_a(fa), .fwd_b(fb), .id_fwd_a(da), .id_fwd_b(db));
    end
    assign o[i] = '{sif, sid, bub, fif, fid, fa, fb, da, db};
  end

  function automatic obs_t mk(logic st, logic bub, logic fif, logic fid,
                              logic [1:0] fa, logic [1:0] fb, logic da, logic db);
    return '{st, st, bub, fif, fid, fa, fb, da, db};
  endfunction

  task automatic apply(input logic [RW-1:0] r1, input logic u1,
                       input logic [RW-1:0] r2, input logic u2, input logic br,
                       input logic [RW-1:0] erd, input logic ew, input logic el,
                       input logic [RW-1:0] mrd, input logic mw, input logic ml,
                       input logic [RW-1:0] wrd, input logic ww, input logic tk);
    @(negedge clk);
    id_rs1 = r1; id_use1 = u1; id_rs2 = r2; id_use2 = u2; id_branch = br;
    ex_rd = erd; ex_wen = ew; ex_load = el;
    mem_rd = mrd; mem_wen = mw; mem_load = ml;
    wb_rd = wrd; wb_wen = ww; br_taken = tk;
  endtask

  task automatic expect_d(input int d, input string req, input obs_t e);
    item_t it;
    it.d = d; it.req = req; it.e = e;
    sb.push_back(it);
  endtask

  task automatic expect_all(input string req, input obs_t e);
    for (int d = 0; d < 4; d++) expect_d(d, req, e);
  endtask

  // monitor: at each rising edge plus a small delay, outputs reflect this cycle's inputs
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (o[it.d] !== it.e) begin
          errors++;
          $display("FAIL %s inst%0d actual=%b expected=%b", it.req, it.d, o[it.d], it.e);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    obs_t z;
    z = mk(0, 0, 0, 0, 2'd0, 2'd0, 0, 0);
    id_rs1 = 0; id_use1 = 0; id_rs2 = 0; id_use2 = 0; id_branch = 0;
    ex_rd = 0; ex_wen = 0; ex_load = 0; mem_rd = 0; mem_wen = 0; mem_load = 0;
    wb_rd = 0; wb_wen = 0; br_taken = 0;
    // drive a dependency during reset: selects must stay at 0 (R1)
    id_rs1 = 5; id_use1 = 1; ex_rd = 5; ex_wen = 1;
    repeat (3) @(posedge clk);
    #1;
    for (int d = 0; d < 4; d++) begin
      checks++;
      if (o[d].fa !== 2'd0 || o[d].fb !== 2'd0) begin
        errors++;
        $display("FAIL R1 inst%0d actual=%0d/%0d expected=0/0", d, o[d].fa, o[d].fb);
      end
    end
    @(negedge clk);
    rst = 0;

    // idle pipeline
    apply(0,0, 0,0, 0, 0,0,0, 0,0,0, 0,0, 0);
    expect_all("R1 idle", z);

    // execute-stage ALU producer
    apply(5,1, 0,0, 0, 5,1,0, 0,0,0, 0,0, 0);
    expect_d(0, "R3 ex producer", mk(1,1,0,0,0,0,0,0));
    expect_d(1, "R4 ex producer", mk(1,1,0,0,0,0,0,0));
    expect_d(2, "R5 ex producer", mk(0,0,0,0,1,0,0,0));
    expect_d(3, "R5 ex producer", mk(0,0,0,0,1,0,0,0));

    // memory-stage ALU producer on operand 2
    apply(0,0, 6,1, 0, 0,0,0, 6,1,0, 0,0, 0);
    expect_d(0, "R3 mem producer", mk(1,1,0,0,0,0,0,0));
    expect_d(1, "R4 mem producer", mk(0,0,0,0,0,2,0,0));
    expect_d(2, "R5 mem producer", mk(0,0,0,0,0,2,0,0));
    expect_d(3, "R5 mem producer", mk(0,0,0,0,0,2,0,0));

    // writeback producer: write-first register file
    apply(7,1, 0,0, 0, 0,0,0, 0,0,0, 7,1, 0);
    expect_all("R3 wb producer", z);

    // register 0 everywhere
    apply(0,1, 0,1, 0, 0,1,0, 0,1,0, 0,1, 0);
    expect_all("R2 reg0", z);

    // match but use flag low
    apply(5,0, 5,0, 0, 5,1,0, 5,1,0, 0,0, 0);
    expect_all("R12 unused source", z);

    // load-use
    apply(8,1, 0,0, 0, 8,1,1, 0,0,0, 0,0, 0);
    expect_all("R6 load-use", mk(1,1,0,0,0,0,0,0));

    // load already in memory
    apply(0,0, 9,1, 0, 0,0,0, 9,1,1, 0,0, 0);
    expect_d(0, "R6 mem load", mk(1,1,0,0,0,0,0,0));
    expect_d(1, "R6 mem load", mk(0,0,0,0,0,2,0,0));
    expect_d(2, "R6 mem load", mk(0,0,0,0,0,2,0,0));
    expect_d(3, "R6 mem load", mk(0,0,0,0,0,2,0,0));

    // same register in execute and memory: newest wins
    apply(3,1, 0,0, 0, 3,1,0, 3,1,0, 0,0, 0);
    expect_d(0, "R11 priority", mk(1,1,0,0,0,0,0,0));
    expect_d(1, "R11 priority", mk(1,1,0,0,0,0,0,0));
    expect_d(2, "R11 priority", mk(0,0,0,0,1,0,0,0));
    expect_d(3, "R11 priority", mk(0,0,0,0,1,0,0,0));

    // taken branch, no dependency
    apply(0,0, 0,0, 1, 0,0,0, 0,0,0, 0,0, 1);
    for (int d = 0; d < 3; d++) expect_d(d, "R8 taken", mk(0,1,1,1,0,0,0,0));
    expect_d(3, "R9 taken", mk(0,0,1,0,0,0,0,0));

    // taken with decode hazard: flush wins in execute builds, stall wins in decode build
    apply(5,1, 0,0, 1, 5,1,0, 0,0,0, 0,0, 1);
    for (int d = 0; d < 3; d++) expect_d(d, "R8 flush over stall", mk(0,1,1,1,0,0,0,0));
    expect_d(3, "R9 taken ignored", mk(1,1,0,0,0,0,0,0));

    // decode branch, memory ALU producer
    apply(4,1, 0,0, 1, 0,0,0, 4,1,0, 0,0, 0);
    expect_d(0, "R10 mem alu", mk(1,1,0,0,0,0,0,0));
    expect_d(1, "R10 mem alu", mk(0,0,0,0,2,0,0,0));
    expect_d(2, "R10 mem alu", mk(0,0,0,0,2,0,0,0));
    expect_d(3, "R10 mem alu", mk(0,0,0,0,2,0,1,0));

    // decode branch, memory load producer
    apply(4,1, 0,0, 1, 0,0,0, 4,1,1, 0,0, 0);
    expect_d(0, "R10 mem load", mk(1,1,0,0,0,0,0,0));
    expect_d(1, "R10 mem load", mk(0,0,0,0,2,0,0,0));
    expect_d(2, "R10 mem load", mk(0,0,0,0,2,0,0,0));
    expect_d(3, "R10 mem load", mk(1,1,0,0,0,0,0,0));

    // decode branch, writeback producer
    apply(4,1, 0,0, 1, 0,0,0, 0,0,0, 4,1, 0);
    expect_all("R10 wb producer", z);

    // decode branch taken with operand forwarded from memory
    apply(0,0, 10,1, 1, 0,0,0, 10,1,0, 0,0, 1);
    for (int d = 0; d < 3; d++) expect_d(d, "R8 flush with mem dep", mk(0,1,1,1,0,0,0,0));
    expect_d(3, "R9 taken forwarded", mk(0,0,1,0,0,2,0,1));

    // after a bubble the selects return to 0
    apply(0,0, 0,0, 0, 0,0,0, 0,0,0, 0,0, 0);
    expect_all("R7 after bubble", z);

    @(posedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule